// File: doc/BRIEF.md
# Programmable Fault Response Manager

This block sits between a set of protection comparators of a motor power stage and the rest of the chip. It receives six fault inputs (overcurrent, overvoltage, undervoltage, over-temperature, supply undervoltage warning and interface fault) and applies a separately programmed response to each. A response can report the fault on an active-low fault line, latch it into sticky status, force the power-stage predriver into high impedance, and recover automatically after a slow or a fast retry time.

Each fault keeps a raw status bit, which clears on its own when retry is selected and the fault has gone away at the end of the retry time, and a latched status bit that survives until an explicit clear pulse or a reset. A summary fault bit and a power-on flag complete the status. All retry timers count a shared prescaled tick, so the time unit can be shrunk for simulation. Mode fields, retry-time selects and the clear pulse come from a register block outside this one; the reset `rst_ni` doubles as the sleep reset.

Top module: `fault_mgr`

## Requirements
- R1: After reset all raw and latched bits and the summary bit are 0, the power-on flag is 1, `fault_no` is 1 and `pd_hiz_o` is 0.
- R2: Fault bits map as 0 overcurrent, 1 overvoltage, 2 undervoltage, 3 over-temperature, 4 supply warning, 5 interface; an enabled fault high at a clock edge sets its raw bit, its latched bit and the summary bit after that edge.
- R3: A retry takes N ticks, N = 1, 2, 4, 10 for select values 0..3 (0.5, 1, 2, 5 time units); the fast retry uses N directly, the slow retry uses N times `SLOW_SCALE`; one tick occurs every `TICK_DIV` clocks.
- R4: If the fault input is still high when the retry time expires, the raw bit stays set and the timer starts again.
- R5: Latched bits and the summary bit stay set until `clr_i`; a clear does not remove the bit of a fault that is high in the same cycle, and clears raw bits of faults without retry.
- R6: Overcurrent mode 0 is slow retry, 1 fast retry, both with predriver high impedance; 2 is high impedance with no retry (clear only); 3 reports only; reserved codes 4..7 behave as 2.
- R7: Overvoltage, undervoltage and over-temperature modes: 0 slow retry, 1 fast retry, both with high impedance; reserved codes 2 and 3 behave as high impedance without retry.
- R8: Supply warning mode: 0 slow retry, 1 fast retry, both with high impedance; 2 reports only; 3 disables the fault.
- R9: Interface fault mode: 0 reports and latches with no predriver action; 1 disables the fault.
- R10: `pd_hiz_o` is 1 exactly while some fault whose mode selects high impedance has its raw bit set.
- R11: `fault_no` is 0 while any enabled fault has its raw or latched bit set, else 1; a disabled fault never sets any status.
- R12: The power-on flag is cleared only by `clr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (also sleep reset) |
| fault_i | input | 6 | Fault inputs, active high |
| clr_i | input | 1 | Clear pulse for latched status |
| oc_mode_i | input | 3 | Overcurrent response mode |
| ov_mode_i | input | 2 | Overvoltage response mode |
| uv_mode_i | input | 2 | Undervoltage response mode |
| ot_mode_i | input | 2 | Over-temperature response mode |
| warn_mode_i | input | 2 | Supply warning response mode |
| if_mode_i | input | 1 | Interface fault response mode |
| slow_sel_i | input | 2 | Slow retry time select |
| fast_sel_i | input | 2 | Fast retry time select |
| raw_o | output | 6 | Raw status bits |
| latched_o | output | 6 | Latched status bits |
| fault_sum_o | output | 1 | Sticky summary fault bit |
| por_o | output | 1 | Power-on flag |
| fault_no | output | 1 | Fault indication, active low |
| pd_hiz_o | output | 1 | Predriver high-impedance request |

## Verification
The bench builds the block with `TICK_DIV` = 2 and `SLOW_SCALE` = 4, so the longest slow retry is 40 ticks, 80 clocks, instead of millions. With a two-clock tick the phase of the prescaler against a fault edge varies, so retry checks accept the one-tick window the requirement allows while the slow-to-fast ratio and the restart on a persisting fault stay fully visible.

// File: rtl/fault_mgr_pkg.sv
package fault_mgr_pkg;
  localparam int NUM_CH = 6;
  localparam int CH_OC   = 0;
  localparam int CH_OV   = 1;
  localparam int CH_UV   = 2;
  localparam int CH_OT   = 3;
  localparam int CH_WARN = 4;
  localparam int CH_IF   = 5;

  typedef struct packed {
    logic en;
    logic hiz;
    logic retry;
    logic slow;
  } resp_t;

  function automatic int unsigned base_ticks(logic [1:0] sel);
    case (sel)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 10;
    endcase
  endfunction

  function automatic resp_t retry_resp(logic slow);
    resp_t r;
    r.en = 1'b1; r.hiz = 1'b1; r.retry = 1'b1; r.slow = slow;
    return r;
  endfunction

  function automatic resp_t hold_resp(logic hiz);
    resp_t r;
    r.en = 1'b1; r.hiz = hiz; r.retry = 1'b0; r.slow = 1'b0;
    return r;
  endfunction

  localparam resp_t OFF_RESP = '0;
endpackage

// File: rtl/fault_mgr_prescaler.sv
module fault_mgr_prescaler #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == CW'(TICK_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = wrap;
    end
  endgenerate
endmodule

// File: rtl/fault_mgr_decode.sv
module fault_mgr_decode
  import fault_mgr_pkg::*;
(
  input  logic [2:0] oc_mode_i,
  input  logic [1:0] ov_mode_i,
  input  logic [1:0] uv_mode_i,
  input  logic [1:0] ot_mode_i,
  input  logic [1:0] warn_mode_i,
  input  logic       if_mode_i,
  output resp_t      resp_o [NUM_CH]
);
  function automatic resp_t dec_two(logic [1:0] m);
    case (m)
      2'd0:    return retry_resp(1'b1);
      2'd1:    return retry_resp(1'b0);
      default: return hold_resp(1'b1);  // reserved: safe stop, clear only
    endcase
  endfunction

  always_comb begin
    case (oc_mode_i)
      3'd0:    resp_o[CH_OC] = retry_resp(1'b1);
      3'd1:    resp_o[CH_OC] = retry_resp(1'b0);
      3'd3:    resp_o[CH_OC] = hold_resp(1'b0);
      default: resp_o[CH_OC] = hold_resp(1'b1);
    endcase
    resp_o[CH_OV] = dec_two(ov_mode_i);
    resp_o[CH_UV] = dec_two(uv_mode_i);
    resp_o[CH_OT] = dec_two(ot_mode_i);
    case (warn_mode_i)
      2'd0:    resp_o[CH_WARN] = retry_resp(1'b1);
      2'd1:    resp_o[CH_WARN] = retry_resp(1'b0);
      2'd2:    resp_o[CH_WARN] = hold_resp(1'b0);
      default: resp_o[CH_WARN] = OFF_RESP;
    endcase
    resp_o[CH_IF] = if_mode_i ? OFF_RESP : hold_resp(1'b0);
  end
endmodule

// File: rtl/fault_mgr_chan.sv
module fault_mgr_chan
  import fault_mgr_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  resp_t            resp_i,
  input  logic [TMR_W-1:0] target_i,
  output logic             raw_o,
  output logic             latched_o,
  output logic             set_o
);
  logic             raw_q, lat_q;
  logic [TMR_W-1:0] cnt_q;
  logic             run, expire;

  assign set_o  = resp_i.en & fault_i;
  assign run    = raw_q & resp_i.retry;
  assign expire = run & tick_i & (cnt_q == target_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      lat_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      // set dominates clear and retry
      if (set_o)                  raw_q <= 1'b1;
      else if (clr_i)             raw_q <= 1'b0;
      else if (expire)            raw_q <= 1'b0;

      if (set_o)                  lat_q <= 1'b1;
      else if (clr_i)             lat_q <= 1'b0;

      // restart on expiry whether or not the fault is gone
      if (!run || expire)         cnt_q <= '0;
      else if (tick_i)            cnt_q <= cnt_q + 1'b1;
    end
  end

  assign raw_o     = raw_q;
  assign latched_o = lat_q;
endmodule

// File: rtl/fault_mgr.sv
module fault_mgr
  import fault_mgr_pkg::*;
#(
  parameter int TICK_DIV   = 50000,
  parameter int SLOW_SCALE = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] fault_i,
  input  logic              clr_i,
  input  logic [2:0]        oc_mode_i,
  input  logic [1:0]        ov_mode_i,
  input  logic [1:0]        uv_mode_i,
  input  logic [1:0]        ot_mode_i,
  input  logic [1:0]        warn_mode_i,
  input  logic              if_mode_i,
  input  logic [1:0]        slow_sel_i,
  input  logic [1:0]        fast_sel_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] latched_o,
  output logic              fault_sum_o,
  output logic              por_o,
  output logic              fault_no,
  output logic              pd_hiz_o
);
  localparam int TMR_W = $clog2(10 * SLOW_SCALE + 1);

  logic              tick;
  resp_t             resp [NUM_CH];
  logic [TMR_W-1:0]  slow_tgt, fast_tgt;
  logic [NUM_CH-1:0] set_vec, en_vec, hiz_vec;
  logic              sum_q, por_q;

  fault_mgr_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  fault_mgr_decode u_dec (
    .oc_mode_i  (oc_mode_i),
    .ov_mode_i  (ov_mode_i),
    .uv_mode_i  (uv_mode_i),
    .ot_mode_i  (ot_mode_i),
    .warn_mode_i(warn_mode_i),
    .if_mode_i  (if_mode_i),
    .resp_o     (resp)
  );

  always_comb begin
    slow_tgt = TMR_W'(base_ticks(slow_sel_i) * SLOW_SCALE);
    fast_tgt = TMR_W'(base_ticks(fast_sel_i));
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    fault_mgr_chan #(.TMR_W(TMR_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fault_i  (fault_i[k]),
      .clr_i    (clr_i),
      .tick_i   (tick),
      .resp_i   (resp[k]),
      .target_i (resp[k].slow ? slow_tgt : fast_tgt),
      .raw_o    (raw_o[k]),
      .latched_o(latched_o[k]),
      .set_o    (set_vec[k])
    );
    assign en_vec[k]  = resp[k].en;
    assign hiz_vec[k] = resp[k].hiz;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= 1'b0;
      por_q <= 1'b1;
    end else begin
      if (|set_vec)   sum_q <= 1'b1;
      else if (clr_i) sum_q <= 1'b0;
      if (clr_i)      por_q <= 1'b0;
    end
  end

  assign fault_sum_o = sum_q;
  assign por_o       = por_q;
  assign fault_no    = ~|(en_vec & (raw_o | latched_o));
  assign pd_hiz_o    = |(hiz_vec & raw_o);
endmodule

// File: rtl/fault_mgr_chk.sv
module fault_mgr_chk
  import fault_mgr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] fault_i,
  input logic              clr_i,
  input logic [NUM_CH-1:0] raw_o,
  input logic [NUM_CH-1:0] latched_o,
  input logic              fault_sum_o,
  input logic              por_o,
  input logic              fault_no,
  input logic              pd_hiz_o
);
  a_r10_hiz_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_hiz_o |-> (|raw_o));

  a_r11_new_latch_drives_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latched_o & ~$past(latched_o)) != '0) |-> !fault_no);

  a_r5_latch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((latched_o & $past(latched_o)) == $past(latched_o)));

  a_r5_clear_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && fault_i == '0) |=> !fault_sum_o);

  a_r12_por_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !por_o);

  a_r12_por_no_reassert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_o |=> !por_o);

  a_r2_latch_with_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latched_o & ~$past(latched_o)) != '0) |-> fault_sum_o);
endmodule

bind fault_mgr fault_mgr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fault_i    (fault_i),
  .clr_i      (clr_i),
  .raw_o      (raw_o),
  .latched_o  (latched_o),
  .fault_sum_o(fault_sum_o),
  .por_o      (por_o),
  .fault_no   (fault_no),
  .pd_hiz_o   (pd_hiz_o)
);

// File: tb/fault_mgr_tb_top.sv
module fault_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int SCALE = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] fault_i = '0;
  logic       clr_i = 1'b0;
  logic [2:0] oc_mode_i = 3'd1;
  logic [1:0] ov_mode_i = 2'd0, uv_mode_i = 2'd1, ot_mode_i = 2'd1;
  logic [1:0] warn_mode_i = 2'd0;
  logic       if_mode_i = 1'b0;
  logic [1:0] slow_sel_i = 2'd0, fast_sel_i = 2'd3;
  logic [5:0] raw_o, latched_o;
  logic       fault_sum_o, por_o, fault_no, pd_hiz_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fault_mgr #(.TICK_DIV(DIV), .SLOW_SCALE(SCALE)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_fault(int ch);
    fault_i = 6'(1 << ch);
    step(1);
    fault_i = '0;
  endtask

  task automatic do_clear();
    clr_i = 1'b1;
    step(1);
    clr_i = 1'b0;
  endtask

  // counts clocks until raw bit ch drops; checks range [lo,hi]
  task automatic wait_raw_clear(int ch, int lo, int hi, string req);
    int n = 0;
    while (raw_o[ch] && n < hi + 5) begin
      step(1);
      n++;
    end
    checks++;
    if (n < lo || n > hi) begin
      errors++;
      $display("FAIL %s: retry took %0d clocks, expected %0d..%0d", req, n, lo, hi);
    end
  endtask

  task automatic t_reset();
    chk("R1 raw", raw_o, 0);
    chk("R1 latched", latched_o, 0);
    chk("R1 summary", fault_sum_o, 0);
    chk("R1 por", por_o, 1);
    chk("R1 fault_no", fault_no, 1);
    chk("R1 hiz", pd_hiz_o, 0);
  endtask

  task automatic t_fast_retry();
    oc_mode_i = 3'd1; fast_sel_i = 2'd0;
    pulse_fault(0);
    chk("R2 oc raw", raw_o[0], 1);
    chk("R2 oc latched", latched_o[0], 1);
    chk("R2 summary", fault_sum_o, 1);
    chk("R10 hiz on fast retry", pd_hiz_o, 1);
    chk("R11 fault_no low", fault_no, 0);
    wait_raw_clear(0, 1, DIV, "R3 fast 1 tick");
    chk("R10 hiz released", pd_hiz_o, 0);
    chk("R5 latched after retry", latched_o[0], 1);
    chk("R11 fault_no held by latch", fault_no, 0);
    do_clear();
    chk("R5 latched cleared", latched_o[0], 0);
    chk("R5 summary cleared", fault_sum_o, 0);
    chk("R11 fault_no released", fault_no, 1);
    chk("R12 por cleared", por_o, 0);
  endtask

  task automatic t_slow_retry();
    ov_mode_i = 2'd0; slow_sel_i = 2'd1;  // 2*SCALE ticks
    pulse_fault(1);
    chk("R7 ov raw", raw_o[1], 1);
    chk("R7 ov hiz", pd_hiz_o, 1);
    wait_raw_clear(1, DIV*(2*SCALE-1)+1, DIV*2*SCALE, "R3 slow 2*SCALE ticks");
    fast_sel_i = 2'd3;
    ot_mode_i = 2'd1;
    pulse_fault(3);
    wait_raw_clear(3, DIV*9+1, DIV*10, "R3 fast 10 ticks");
    do_clear();
  endtask

  task automatic t_restart();
    uv_mode_i = 2'd1; fast_sel_i = 2'd2;
    fault_i = 6'b000100;
    step(20);
    chk("R4 raw held while fault stays", raw_o[2], 1);
    fault_i = '0;
    wait_raw_clear(2, 1, DIV*4, "R4 clear after restart");
    do_clear();
  endtask

  task automatic t_oc_modes();
    oc_mode_i = 3'd2;
    pulse_fault(0);
    step(50);
    chk("R6 manual raw held", raw_o[0], 1);
    chk("R6 manual hiz held", pd_hiz_o, 1);
    do_clear();
    chk("R6 manual cleared", raw_o[0], 0);
    chk("R10 hiz off after clear", pd_hiz_o, 0);
    oc_mode_i = 3'd3;
    pulse_fault(0);
    chk("R6 report raw", raw_o[0], 1);
    chk("R6 report no hiz", pd_hiz_o, 0);
    chk("R11 report fault_no", fault_no, 0);
    step(30);
    chk("R6 report no auto clear", raw_o[0], 1);
    do_clear();
    oc_mode_i = 3'd5;
    pulse_fault(0);
    step(30);
    chk("R6 reserved acts as manual", raw_o[0], 1);
    chk("R6 reserved hiz", pd_hiz_o, 1);
    do_clear();
    ov_mode_i = 2'd3;
    pulse_fault(1);
    step(30);
    chk("R7 reserved raw held", raw_o[1], 1);
    chk("R7 reserved hiz", pd_hiz_o, 1);
    do_clear();
    oc_mode_i = 3'd1; ov_mode_i = 2'd0;
  endtask

  task automatic t_warn_if();
    warn_mode_i = 2'd3; if_mode_i = 1'b1;
    fault_i = 6'b110000;
    step(1);
    fault_i = '0;
    chk("R8 warn disabled", raw_o[4] | latched_o[4], 0);
    chk("R9 if disabled", raw_o[5] | latched_o[5], 0);
    chk("R11 disabled no fault", fault_no, 1);
    chk("R11 disabled no summary", fault_sum_o, 0);
    warn_mode_i = 2'd2; if_mode_i = 1'b0;
    fault_i = 6'b110000;
    step(1);
    fault_i = '0;
    chk("R8 warn report latched", latched_o[4], 1);
    chk("R9 if report latched", latched_o[5], 1);
    chk("R9 no hiz", pd_hiz_o, 0);
    do_clear();
    warn_mode_i = 2'd1; fast_sel_i = 2'd1;
    pulse_fault(4);
    chk("R8 warn retry hiz", pd_hiz_o, 1);
    wait_raw_clear(4, DIV+1, DIV*2, "R8 warn fast retry");
    do_clear();
  endtask

  task automatic t_clear_vs_fault();
    oc_mode_i = 3'd2;
    fault_i = 6'b000001;
    step(2);
    clr_i = 1'b1;
    step(1);
    clr_i = 1'b0;
    chk("R5 clear blocked by active fault", latched_o[0], 1);
    chk("R5 summary kept", fault_sum_o, 1);
    fault_i = '0;
    do_clear();
    chk("R5 clear after fault gone", latched_o[0], 0);
    chk("R12 por stays low", por_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_fast_retry();
    t_slow_retry();
    t_restart();
    t_oc_modes();
    t_warn_if();
    t_clear_vs_fault();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule